// File: doc/BRIEF.md
# Flash write status responder

This block sits on the device side of a NOR-style flash memory. It produces the status a host sees on reads while an internal program or erase operation is running. A command decoder elsewhere hands it each accepted command as a one-cycle strobe, with a kind code, an address and a data byte. A protection store supplies one protect bit per sector. From these the block keeps its own record of the operation in flight: the target address, bit 7 of the datum being written, the set of sectors picked for erase, and whether the erase is suspended.

On each read strobe the block registers a status byte and a `stat_hit` flag. When `stat_hit` is 0, the read belongs to the array, and the byte from this block is zero. When `stat_hit` is 1, the byte replaces the array data. Bit 7 is the polling bit. It holds the complement of the final value until the operation ends. Bit 5 reports that an operation overran its cycle budget. A registered `ready` output is low whenever the device is busy.

Operation lengths are parameters counted in clock cycles. This covers the normal program and per-sector erase times, and the short busy windows shown for requests that touch only protected sectors. The sector number is the top `SECT_BITS` bits of an address.

Top module: `flash_status_resp`

## Requirements
- R1: After reset `ready` is 1, `stat_hit` is 0 and `stat` is 0.
- R2: A program command (kind code 0, datum on `cmd_data`) to an unprotected sector holds `ready` low for exactly PROG_CYC cycles, starting the cycle after acceptance. While it is busy, a read at exactly the program address gives `stat_hit`=1 and bit 7 equal to the inverse of datum bit 7. A read at any other address gives `stat_hit`=0.
- R3: Once an operation ends, `ready` is 1 and reads give `stat_hit`=0.
- R4: Sector erase (code 1) selects the sectors whose bits are set in `cmd_data[2**SECT_BITS-1:0]`. Chip erase (code 2) selects every sector. `ready` stays low for ERASE_CYC times the number of selected unprotected sectors. Protected selected sectors are skipped without notice. While busy, a read in a selected sector gives `stat_hit`=1 with bit 7 = 0, and a read in any other sector gives `stat_hit`=0.
- R5: Suspend (code 3) during an erase raises `ready`. Reads in selected sectors then give `stat_hit`=1 with bit 7 = 1. Resume (code 4) continues the erase, and the total busy time counted before and after the suspend stays ERASE_CYC times the sector count.
- R6: A program accepted while suspended behaves as in R2. Afterwards the block returns to the suspended state: `ready` is 1 and reads in the erase sectors give bit 7 = 1.
- R7: A program to a sector whose `prot_mask` bit is 1 holds `ready` low for GUARD_PROG_CYC cycles, with the inverted bit 7 at the program address. After that, reads return to the array.
- R8: An erase whose selected sectors are all protected holds `ready` low for GUARD_ERASE_CYC cycles with bit 7 = 0 in the selected sectors. After that, reads return to the array.
- R9: An operation whose run time would exceed LIMIT_CYC cycles stops after LIMIT_CYC running cycles. From then on, status reads also show bit 5 = 1 and `ready` stays low. Only a reset command (code 5) clears this; in any other state that code has no effect.
- R10: Program and erase commands arriving while an operation is active are ignored, and the running operation's length and status are unchanged.
- R11: Only bits 7 and 5 of `stat` can be 1, and `stat` is all zero whenever `stat_hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe for an accepted command |
| cmd_kind | input | 3 | Command code: 0 program, 1 sector erase, 2 chip erase, 3 suspend, 4 resume, 5 reset |
| cmd_addr | input | ADDR_W | Program address (top SECT_BITS bits select the sector) |
| cmd_data | input | 8 | Program datum, or sector-select mask for sector erase |
| prot_mask | input | 2**SECT_BITS | Protect bit per sector, 1 = protected |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| ready | output | 1 | High when no operation or protected-sector window is active |
| stat | output | 8 | Registered status byte (bit 7 polling, bit 5 overrun) |
| stat_hit | output | 1 | 1 when the read returns status instead of array data |

## Verification
The bench sweeps every erase mask against every protection pattern, and both erase kinds. This catches a design that counts protected sectors into the busy time, one that never enters the protected-only window, and one whose overrun check fires too early or never fires. Programs with data of both bit-7 polarities in every sector catch a polling bit that is not inverted, or that answers at the wrong address. A suspend and resume with a program inside it catches a design that loses erase time or keeps counting while suspended. Commands injected during a running erase expose a design that restarts or retargets the operation instead of ignoring them.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  typedef enum logic [2:0] {
    K_PROG   = 3'd0,
    K_SERASE = 3'd1,
    K_CERASE = 3'd2,
    K_SUSP   = 3'd3,
    K_RESUME = 3'd4,
    K_RESET  = 3'd5
  } fsr_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_PROG  = 3'd1,
    S_ERASE = 3'd2,
    S_SUSP  = 3'd3,
    S_SPROG = 3'd4,
    S_GUARD = 3'd5,
    S_FAIL  = 3'd6
  } fsr_state_e;
endpackage

// File: rtl/fsr_sector_map.sv
module fsr_sector_map #(
  parameter int ADDR_W    = 8,
  parameter int SECT_BITS = 2,
  localparam int NS       = 1 << SECT_BITS
) (
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [NS-1:0]      cand_mask,
  input  logic [NS-1:0]      sel_mask,
  input  logic [NS-1:0]      prot_mask,
  output logic               cmd_prot,
  output logic               rd_in_sel,
  output logic [SECT_BITS:0] n_live
);
  logic [SECT_BITS-1:0] cmd_sect;
  logic [SECT_BITS-1:0] rd_sect;

  assign cmd_sect  = cmd_addr[ADDR_W-1 -: SECT_BITS];
  assign rd_sect   = rd_addr[ADDR_W-1 -: SECT_BITS];
  assign cmd_prot  = prot_mask[cmd_sect];
  assign rd_in_sel = sel_mask[rd_sect];

  always_comb begin
    n_live = '0;
    for (int i = 0; i < NS; i++) begin
      n_live = n_live + (SECT_BITS+1)'(cand_mask[i] & ~prot_mask[i]);
    end
  end
endmodule

// File: rtl/fsr_op_timer.sv
module fsr_op_timer #(
  parameter int CNT_W = 8,
  parameter int LIMIT = 40,
  localparam int LW   = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  input  logic             run,
  input  logic             chk,
  output logic             done,
  output logic             expire
);
  logic [CNT_W-1:0] rem_q;
  logic [LW-1:0]    el_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      el_q  <= '0;
    end else if (load) begin
      rem_q <= len;
      el_q  <= '0;
    end else if (run && rem_q != '0) begin
      rem_q <= rem_q - 1'b1;
      if (el_q != '1) el_q <= el_q + 1'b1;
    end
  end

  assign done   = run && (rem_q == CNT_W'(1));
  assign expire = run && chk && (rem_q > CNT_W'(1)) && (el_q == LW'(LIMIT - 1));
endmodule

// File: rtl/fsr_read_fmt.sv
module fsr_read_fmt
  import flash_stat_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic              prog_b7,
  input  logic              op_prog,
  input  logic              rd_in_sel,
  input  fsr_state_e        state,
  output logic [7:0]        stat,
  output logic              stat_hit
);
  logic prog_like, erase_like, susp_like, hit_n, b7_n, b5_n;

  always_comb begin
    prog_like  = (state == S_PROG) || (state == S_SPROG) ||
                 (((state == S_GUARD) || (state == S_FAIL)) && op_prog);
    erase_like = (state == S_ERASE) ||
                 (((state == S_GUARD) || (state == S_FAIL)) && !op_prog);
    susp_like  = (state == S_SUSP) || (state == S_SPROG);
    hit_n = 1'b0;
    b7_n  = 1'b0;
    if (prog_like && rd_addr == prog_addr) begin
      hit_n = 1'b1;
      b7_n  = ~prog_b7;
    end else if (erase_like && rd_in_sel) begin
      hit_n = 1'b1;
    end else if (susp_like && rd_in_sel) begin
      hit_n = 1'b1;
      b7_n  = 1'b1;
    end
    b5_n = hit_n && (state == S_FAIL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat     <= '0;
      stat_hit <= 1'b0;
    end else if (rd_en) begin
      stat     <= {b7_n, 1'b0, b5_n, 5'b0};
      stat_hit <= hit_n;
    end
  end
endmodule

// File: rtl/flash_status_resp.sv
module flash_status_resp
  import flash_stat_pkg::*;
#(
  parameter int ADDR_W          = 8,
  parameter int SECT_BITS       = 2,
  parameter int PROG_CYC        = 6,
  parameter int ERASE_CYC       = 16,
  parameter int GUARD_PROG_CYC  = 10,
  parameter int GUARD_ERASE_CYC = 24,
  parameter int LIMIT_CYC       = 40,
  localparam int NS             = 1 << SECT_BITS,
  localparam int ERASE_MAX      = ERASE_CYC * NS,
  localparam int M1             = (PROG_CYC > GUARD_PROG_CYC) ? PROG_CYC : GUARD_PROG_CYC,
  localparam int M2             = (ERASE_MAX > GUARD_ERASE_CYC) ? ERASE_MAX : GUARD_ERASE_CYC,
  localparam int LMAX           = (M1 > M2) ? M1 : M2,
  localparam int CW             = $clog2(LMAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic [NS-1:0]     prot_mask,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              ready,
  output logic [7:0]        stat,
  output logic              stat_hit
);
  fsr_state_e        state_q, state_nx;
  logic [ADDR_W-1:0] prog_addr_q;
  logic              prog_b7_q, op_prog_q, in_susp_q;
  logic [NS-1:0]     sel_q, cand_mask;
  logic              cmd_prot, rd_in_sel;
  logic [SECT_BITS:0] n_live;
  logic              take_prog, take_erase, ld_p, ld_e;
  logic [CW-1:0]     len_p, len_e;
  logic              p_done, p_exp, e_done, e_exp;
  logic              run_p, chk_p, run_e;
  fsr_cmd_e          kind;

  assign kind      = fsr_cmd_e'(cmd_kind);
  assign cand_mask = (kind == K_CERASE) ? {NS{1'b1}} : cmd_data[NS-1:0];

  fsr_sector_map #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS)) u_map (
    .cmd_addr(cmd_addr), .rd_addr(rd_addr), .cand_mask(cand_mask),
    .sel_mask(sel_q), .prot_mask(prot_mask),
    .cmd_prot(cmd_prot), .rd_in_sel(rd_in_sel), .n_live(n_live)
  );

  always_comb begin
    state_nx   = state_q;
    take_prog  = 1'b0;
    take_erase = 1'b0;
    ld_p       = 1'b0;
    ld_e       = 1'b0;
    len_p      = CW'(PROG_CYC);
    len_e      = CW'(n_live) * CW'(ERASE_CYC);
    unique case (state_q)
      S_IDLE: if (cmd_valid) begin
        if (kind == K_PROG) begin
          take_prog = 1'b1;
          ld_p      = 1'b1;
          if (cmd_prot) begin
            len_p    = CW'(GUARD_PROG_CYC);
            state_nx = S_GUARD;
          end else begin
            state_nx = S_PROG;
          end
        end else if ((kind == K_SERASE || kind == K_CERASE) && cand_mask != '0) begin
          take_erase = 1'b1;
          if (n_live == '0) begin
            ld_p     = 1'b1;
            len_p    = CW'(GUARD_ERASE_CYC);
            state_nx = S_GUARD;
          end else begin
            ld_e     = 1'b1;
            state_nx = S_ERASE;
          end
        end
      end
      S_PROG:  if (p_exp) state_nx = S_FAIL; else if (p_done) state_nx = S_IDLE;
      S_ERASE: if (e_exp) state_nx = S_FAIL;
               else if (e_done) state_nx = S_IDLE;
               else if (cmd_valid && kind == K_SUSP) state_nx = S_SUSP;
      S_SUSP: if (cmd_valid) begin
        if (kind == K_RESUME) begin
          state_nx = S_ERASE;
        end else if (kind == K_PROG) begin
          take_prog = 1'b1;
          ld_p      = 1'b1;
          if (cmd_prot) begin
            len_p    = CW'(GUARD_PROG_CYC);
            state_nx = S_GUARD;
          end else begin
            state_nx = S_SPROG;
          end
        end
      end
      S_SPROG: if (p_exp) state_nx = S_FAIL; else if (p_done) state_nx = S_SUSP;
      S_GUARD: if (p_done) state_nx = in_susp_q ? S_SUSP : S_IDLE;
      S_FAIL:  if (cmd_valid && kind == K_RESET) state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  assign run_p = (state_q == S_PROG) || (state_q == S_SPROG) || (state_q == S_GUARD);
  assign chk_p = (state_q != S_GUARD);
  assign run_e = (state_q == S_ERASE);

  fsr_op_timer #(.CNT_W(CW), .LIMIT(LIMIT_CYC)) u_ptmr (
    .clk(clk), .rst(rst), .load(ld_p), .len(len_p), .run(run_p), .chk(chk_p),
    .done(p_done), .expire(p_exp)
  );

  fsr_op_timer #(.CNT_W(CW), .LIMIT(LIMIT_CYC)) u_etmr (
    .clk(clk), .rst(rst), .load(ld_e), .len(len_e), .run(run_e), .chk(1'b1),
    .done(e_done), .expire(e_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      ready       <= 1'b1;
      prog_addr_q <= '0;
      prog_b7_q   <= 1'b0;
      op_prog_q   <= 1'b0;
      in_susp_q   <= 1'b0;
      sel_q       <= '0;
    end else begin
      state_q <= state_nx;
      ready   <= (state_nx == S_IDLE) || (state_nx == S_SUSP);
      if (take_prog) begin
        prog_addr_q <= cmd_addr;
        prog_b7_q   <= cmd_data[7];
        op_prog_q   <= 1'b1;
        in_susp_q   <= (state_q == S_SUSP);
      end else if (take_erase) begin
        sel_q     <= cand_mask;
        op_prog_q <= 1'b0;
        in_susp_q <= 1'b0;
      end
    end
  end

  fsr_read_fmt #(.ADDR_W(ADDR_W)) u_fmt (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .prog_addr(prog_addr_q), .prog_b7(prog_b7_q), .op_prog(op_prog_q),
    .rd_in_sel(rd_in_sel), .state(state_q), .stat(stat), .stat_hit(stat_hit)
  );
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
  import flash_stat_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [2:0]        cmd_kind,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              ready,
  input logic [7:0]        stat,
  input logic              stat_hit,
  input fsr_state_e        state,
  input logic [ADDR_W-1:0] prog_addr,
  input logic              prog_b7
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (ready && !stat_hit && stat == 8'h00));

  assert_prog_inverted_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && state == S_PROG && rd_addr == prog_addr)
      |=> (stat_hit && stat[7] == !$past(prog_b7)));

  assert_idle_array_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && state == S_IDLE) |=> !stat_hit);

  assert_erase_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && state == S_ERASE) |=> !stat[7]);

  assert_suspend_ready_R5: assert property (@(posedge clk) disable iff (rst)
    (state == S_SUSP) |-> ready);

  assert_fail_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (state == S_FAIL) |-> !ready);

  assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (state == S_FAIL && !(cmd_valid && cmd_kind == 3'd5)) |=> (state == S_FAIL));

  assert_spare_bits_R11: assert property (@(posedge clk) disable iff (rst)
    ((stat & 8'h5F) == 8'h00) && (stat_hit || stat == 8'h00));
endmodule

bind flash_status_resp fsr_checker #(.ADDR_W(ADDR_W)) u_fsr_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
  .rd_en(rd_en), .rd_addr(rd_addr), .ready(ready), .stat(stat),
  .stat_hit(stat_hit), .state(state_q), .prog_addr(prog_addr_q),
  .prog_b7(prog_b7_q)
);

// File: tb/tb_flash_status_resp.sv
`timescale 1ns/1ps
module tb_flash_status_resp;
  localparam int AW = 8, SB = 2, NS = 4;
  localparam int PC = 6, EC = 16, GP = 10, GE = 24, LIM = 40;
  localparam int CAP = LIM + 4;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_kind = '0;
  logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic [NS-1:0] prot_mask = '0;
  logic rd_en = 1'b0;
  logic ready, stat_hit;
  logic [7:0] stat;
  int nchk = 0, nfail = 0;

  flash_status_resp #(.ADDR_W(AW), .SECT_BITS(SB), .PROG_CYC(PC), .ERASE_CYC(EC),
    .GUARD_PROG_CYC(GP), .GUARD_ERASE_CYC(GE), .LIMIT_CYC(LIM)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .prot_mask(prot_mask),
    .rd_en(rd_en), .rd_addr(rd_addr), .ready(ready), .stat(stat), .stat_hit(stat_hit));

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit stat_bad(input bit ehit, input bit eb7);
    if ((stat & 8'h5F) != 0) return 1'b1;
    if (!stat_hit && stat != 0) return 1'b1;
    if (stat_hit != ehit) return 1'b1;
    if (ehit && stat[7] != eb7) return 1'b1;
    return 1'b0;
  endfunction

  task automatic op_track(input logic [2:0] k, input logic [AW-1:0] a, input logic [7:0] d,
                          input logic [AW-1:0] ra, input bit ehit, input bit eb7,
                          output int nlow, output int bad);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = k; cmd_addr = a; cmd_data = d;
    rd_en = 1'b1; rd_addr = ra;
    @(negedge clk);
    cmd_valid = 1'b0;
    nlow = 0; bad = 0;
    while (!ready && nlow < CAP) begin
      nlow++;
      @(negedge clk);
      if (stat_bad(ehit, eb7)) bad++;
    end
    rd_en = 1'b0;
  endtask

  task automatic rd_once(input logic [AW-1:0] a);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic send(input logic [2:0] k, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = k; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int nlow, bad;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(ready == 1'b1, "R1 ready", ready, 1);
    check(stat_hit == 1'b0 && stat == 0, "R1 status", stat, 0);

    // R2/R3 programs, every sector, both bit-7 polarities
    for (int s = 0; s < NS; s++) begin
      for (int j = 0; j < 4; j++) begin
        logic [7:0] d;
        logic [AW-1:0] a;
        d = (j == 0) ? 8'h00 : (j == 1) ? 8'h80 : (j == 2) ? 8'h5A : 8'hC3;
        a = {s[1:0], 6'(j * 9 + 3)};
        op_track(3'd0, a, d, a, 1'b1, ~d[7], nlow, bad);
        check(nlow == PC, "R2 program busy", nlow, PC);
        check(bad == 0, "R2 polling bit", bad, 0);
        rd_once(a);
        check(ready && !stat_hit, "R3 back to array", stat_hit, 0);
        op_track(3'd0, a, d, a ^ 8'h01, 1'b0, 1'b0, nlow, bad);
        check(bad == 0, "R2 other address no hit", bad, 0);
      end
    end

    // R4/R8/R9/R11 erase sweep over masks and protection
    for (int p = 0; p < 16; p++) begin
      prot_mask = p[3:0];
      for (int m = 1; m <= 16; m++) begin
        logic [3:0] mask;
        int n, len, lo;
        bit fail;
        mask = (m == 16) ? 4'hF : m[3:0];
        n = $countones(mask & ~p[3:0]);
        len = (n == 0) ? GE : n * EC;
        fail = (n > 0) && (len > LIM);
        lo = 0;
        while (!mask[lo]) lo++;
        op_track((m == 16) ? 3'd2 : 3'd1, 8'h00, {4'h0, mask}, {lo[1:0], 6'h2A},
                 1'b1, 1'b0, nlow, bad);
        check(nlow == (fail ? CAP : len), (n == 0) ? "R8 guard erase busy" : "R4 erase busy",
              nlow, fail ? CAP : len);
        check(bad == 0, "R4 erase polling R11", bad, 0);
        if (fail) begin
          check(stat[5] == 1'b1 && ready == 1'b0, "R9 overrun flag", stat, 8'h20);
          send(3'd5, 8'h00, 8'h00);
          check(ready == 1'b1, "R9 reset command clears", ready, 1);
        end else begin
          check(stat[5] == 1'b0, "R9 no overrun", stat[5], 0);
        end
        if (p == 0 && mask != 4'hF && !fail) begin
          int hi;
          hi = 0;
          while (mask[hi]) hi++;
          op_track(3'd1, 8'h00, {4'h0, mask}, {hi[1:0], 6'h11}, 1'b0, 1'b0, nlow, bad);
          check(bad == 0, "R4 unselected sector no hit", bad, 0);
        end
      end
    end
    prot_mask = '0;

    // R9 reset command ignored while not failed
    send(3'd5, 8'h00, 8'h00);
    check(ready == 1'b1, "R9 reset idle no effect", ready, 1);

    // R7 protected program
    prot_mask = 4'b0100;
    op_track(3'd0, 8'h8C, 8'h7E, 8'h8C, 1'b1, 1'b1, nlow, bad);
    check(nlow == GP, "R7 guard program busy", nlow, GP);
    check(bad == 0, "R7 guard polling", bad, 0);
    rd_once(8'h8C);
    check(!stat_hit, "R7 back to array", stat_hit, 0);
    prot_mask = '0;

    // R5/R6 suspend, program inside, resume
    begin
      int pre;
      pre = 0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_kind = 3'd1; cmd_data = 8'h01; rd_en = 1'b1; rd_addr = 8'h05;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (5) begin
        if (!ready) pre++;
        @(negedge clk);
      end
      if (!ready) pre++;
      cmd_valid = 1'b1; cmd_kind = 3'd3;
      @(negedge clk);
      cmd_valid = 1'b0;
      check(ready == 1'b1, "R5 suspend ready", ready, 1);
      @(negedge clk);
      check(stat_hit && stat[7], "R5 suspended bit7", stat, 8'h80);
      rd_en = 1'b0;
      op_track(3'd0, 8'h85, 8'h11, 8'h85, 1'b1, 1'b1, nlow, bad);
      check(nlow == PC, "R6 program in suspend busy", nlow, PC);
      check(bad == 0, "R6 program in suspend polling", bad, 0);
      rd_once(8'h05);
      check(ready && stat_hit && stat[7], "R6 back to suspend", stat, 8'h80);
      op_track(3'd4, 8'h00, 8'h00, 8'h05, 1'b1, 1'b0, nlow, bad);
      check(pre + nlow == EC, "R5 resumed total", pre + nlow, EC);
      check(bad == 0, "R5 resumed polling", bad, 0);
    end

    // R10 commands during an active erase are ignored
    begin
      int low, cyc;
      low = 0; cyc = 0; bad = 0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_kind = 3'd1; cmd_data = 8'h04; rd_en = 1'b1; rd_addr = 8'h9A;
      @(negedge clk);
      cmd_valid = 1'b0;
      while (!ready && low < CAP) begin
        low++; cyc++;
        cmd_valid = (cyc >= 3 && cyc <= 5);
        cmd_kind = (cyc == 3) ? 3'd0 : (cyc == 4) ? 3'd2 : 3'd5;
        cmd_addr = 8'h10; cmd_data = 8'h0F;
        @(negedge clk);
        if (stat_bad(1'b1, 1'b0)) bad++;
      end
      cmd_valid = 1'b0; rd_en = 1'b0;
      check(low == EC, "R10 erase length kept", low, EC);
      check(bad == 0, "R10 erase status kept", bad, 0);
      rd_once(8'h10);
      check(!stat_hit, "R10 ignored program no status", stat_hit, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule